// File: doc/BRIEF.md
# Hardwired Micro-Step Accumulator Core

This block is a small accumulator machine whose control is pure decode logic. There is no control store. A 2-bit cycle code names the current phase: fetch, indirect, execute or interrupt. A 2-bit step counter selects the register transfer that happens inside that phase. Each clock edge completes exactly one step. The decoder drives the load enables of the address register, buffer register, program counter, instruction register and accumulator. It also drives the memory strobes.

Instruction words are 16 bits. Bit 15 requests indirect addressing. Bits 14:12 hold the opcode: 000 add, 001 increment-and-skip-if-zero, 010 branch-and-save, 111 halt. Bits 11:0 hold the address. The memory is single-port and is addressed from the address register. It is written from the buffer register.

The memory port is a plain strobe interface with no back-pressure. A read strobe expects data on `mem_rdata` within the same cycle, and that data is captured at the closing edge. A write takes effect at the closing edge of the cycle in which the write strobe is high. The memory can never stall the core, so it must meet that timing.

Top module: `hwseq_core`

## Requirements
- R1: While reset is low, `halted`, `acc_out`, `mem_rd`, `mem_wr` and `mem_addr` are all zero. After reset is released, the first fetch reads address 0, and interrupts start out enabled.
- R2: Fetch takes three cycles. Cycle 1 performs no memory access. Cycle 2 reads the word at PC and advances PC. Cycle 3 moves the word into the instruction register. No write ever happens during fetch.
- R3: When bit 15 of the fetched word is set, a three-cycle indirect phase comes next. Its second cycle reads the pointer word at address bits 11:0. The low 12 bits of that pointer become the operand address, and its upper 4 bits are ignored.
- R4: Opcode 000 (add) takes three execute cycles. The operand is read in the second cycle, and the accumulator gains the operand modulo 2^16.
- R5: Opcode 001 (increment-and-skip) takes four execute cycles. It writes the operand plus one back in the fourth cycle. If that result is zero, the next instruction is skipped.
- R6: Opcode 010 (branch-and-save) takes three execute cycles. In the second cycle it writes the address of the following instruction (upper 4 bits zero) to operand address X. Execution then continues at X+1.
- R7: An interrupt is entered only when an execute phase completes with `irq` high and interrupts enabled. Entry takes three cycles. It writes PC to address 0 in the third cycle, resumes at address 1 and disables interrupts, so later requests are ignored.
- R8: Opcode 111 (halt) raises `halted` one execute cycle after its fetch. `halted` then stays high, and no memory strobe occurs again until reset.
- R9: Opcodes 011 through 110 complete in a single execute cycle. They change neither memory nor the accumulator.
- R10: `mem_rd` and `mem_wr` are never high in the same cycle. Read data is captured in the cycle the read strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq | input | 1 | Interrupt request level |
| mem_addr | output | 12 | Memory address, driven from the address register |
| mem_rd | output | 1 | Read strobe; data is taken the same cycle |
| mem_wr | output | 1 | Write strobe; the write happens at the closing edge |
| mem_wdata | output | 16 | Write data, driven from the buffer register |
| mem_rdata | input | 16 | Read data from memory |
| acc_out | output | 16 | Accumulator value |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The bench uses the default parameters: a 12-bit address, 16-bit words, save address 0 and routine address 1. With a save slot and routine this close to the program area, one short directed program covers interrupt entry and the ignored second request. Randomly built programs of up to sixteen instructions, with pointer words and all-ones data words, reach the skip, indirect and forward-branch paths. An instruction-level model predicts the final memory image, the accumulator and the total cycle count for each program.

// File: rtl/hwseq_pkg.sv
package hwseq_pkg;

  typedef enum logic [1:0] {
    PH_FETCH = 2'b00,
    PH_IND   = 2'b01,
    PH_EXEC  = 2'b10,
    PH_INT   = 2'b11
  } phase_t;

  localparam int STEP_W = 2;

  localparam logic [2:0] OPC_ADD  = 3'b000;
  localparam logic [2:0] OPC_ISZ  = 3'b001;
  localparam logic [2:0] OPC_BSA  = 3'b010;
  localparam logic [2:0] OPC_HALT = 3'b111;

  typedef struct packed {
    logic   mar_from_pc;
    logic   mar_from_ir;
    logic   mar_from_save;
    logic   mbr_from_mem;
    logic   mbr_from_pc;
    logic   mbr_inc;
    logic   pc_inc;
    logic   pc_from_ir;
    logic   pc_from_isr;
    logic   ir_from_mbr;
    logic   iraddr_from_mbr;
    logic   acc_add;
    logic   mem_rd;
    logic   mem_wr;
    logic   ie_clr;
    logic   last;
    phase_t nxt;
    logic   halt_set;
  } ctl_t;

endpackage

// File: rtl/hwseq_timing.sv
module hwseq_timing
  import hwseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              last,
  input  phase_t            nxt,
  input  logic              halt_set,
  output phase_t            phase,
  output logic [STEP_W-1:0] step,
  output logic              halted
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_FETCH;
      step   <= '0;
      halted <= 1'b0;
    end else if (!halted) begin
      if (halt_set) begin
        halted <= 1'b1;
      end else if (last) begin
        phase <= nxt;
        step  <= '0;
      end else begin
        step <= step + STEP_W'(1);
      end
    end
  end

endmodule

// File: rtl/hwseq_decode.sv
module hwseq_decode
  import hwseq_pkg::*;
(
  input  phase_t            phase,
  input  logic [STEP_W-1:0] step,
  input  logic [2:0]        opcode,
  input  logic              mbr_ind,
  input  logic              mbr_zero,
  input  logic              irq,
  input  logic              ie,
  input  logic              halted,
  output ctl_t              ctl
);

  phase_t after_exec;

  always_comb begin
    after_exec = (irq && ie) ? PH_INT : PH_FETCH;
  end

  always_comb begin
    ctl     = '0;
    ctl.nxt = phase;
    if (!halted) begin
      unique case (phase)
        PH_FETCH: begin
          case (step)
            2'd0: ctl.mar_from_pc = 1'b1;
            2'd1: begin
              ctl.mem_rd       = 1'b1;
              ctl.mbr_from_mem = 1'b1;
              ctl.pc_inc       = 1'b1;
            end
            default: begin
              ctl.ir_from_mbr = 1'b1;
              ctl.last        = 1'b1;
              ctl.nxt         = mbr_ind ? PH_IND : PH_EXEC;
            end
          endcase
        end
        PH_IND: begin
          case (step)
            2'd0: ctl.mar_from_ir = 1'b1;
            2'd1: begin
              ctl.mem_rd       = 1'b1;
              ctl.mbr_from_mem = 1'b1;
            end
            default: begin
              ctl.iraddr_from_mbr = 1'b1;
              ctl.last            = 1'b1;
              ctl.nxt             = PH_EXEC;
            end
          endcase
        end
        PH_EXEC: begin
          ctl.nxt = after_exec;
          case (opcode)
            OPC_ADD: begin
              case (step)
                2'd0: ctl.mar_from_ir = 1'b1;
                2'd1: begin
                  ctl.mem_rd       = 1'b1;
                  ctl.mbr_from_mem = 1'b1;
                end
                default: begin
                  ctl.acc_add = 1'b1;
                  ctl.last    = 1'b1;
                end
              endcase
            end
            OPC_ISZ: begin
              case (step)
                2'd0: ctl.mar_from_ir = 1'b1;
                2'd1: begin
                  ctl.mem_rd       = 1'b1;
                  ctl.mbr_from_mem = 1'b1;
                end
                2'd2: ctl.mbr_inc = 1'b1;
                default: begin
                  ctl.mem_wr = 1'b1;
                  ctl.pc_inc = mbr_zero;
                  ctl.last   = 1'b1;
                end
              endcase
            end
            OPC_BSA: begin
              case (step)
                2'd0: begin
                  ctl.mar_from_ir = 1'b1;
                  ctl.mbr_from_pc = 1'b1;
                end
                2'd1: begin
                  ctl.pc_from_ir = 1'b1;
                  ctl.mem_wr     = 1'b1;
                end
                default: begin
                  ctl.pc_inc = 1'b1;
                  ctl.last   = 1'b1;
                end
              endcase
            end
            OPC_HALT: ctl.halt_set = 1'b1;
            default:  ctl.last     = 1'b1;
          endcase
        end
        PH_INT: begin
          case (step)
            2'd0: ctl.mbr_from_pc = 1'b1;
            2'd1: begin
              ctl.mar_from_save = 1'b1;
              ctl.pc_from_isr   = 1'b1;
              ctl.ie_clr        = 1'b1;
            end
            default: begin
              ctl.mem_wr = 1'b1;
              ctl.last   = 1'b1;
              ctl.nxt    = PH_FETCH;
            end
          endcase
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/hwseq_datapath.sv
module hwseq_datapath
  import hwseq_pkg::*;
#(
  parameter int AW        = 12,
  parameter int DW        = 16,
  parameter int SAVE_ADDR = 0,
  parameter int ISR_ADDR  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_t          ctl,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] mar,
  output logic [DW-1:0] mbr,
  output logic [DW-1:0] acc,
  output logic [2:0]    opcode,
  output logic          ie
);

  localparam int PADW = DW - AW;

  logic [AW-1:0] pc;
  logic [DW-2:0] ir;

  assign opcode = ir[DW-2:AW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar <= '0;
      mbr <= '0;
      pc  <= '0;
      ir  <= '0;
      acc <= '0;
      ie  <= 1'b1;
    end else begin
      if (ctl.mar_from_pc)        mar <= pc;
      else if (ctl.mar_from_ir)   mar <= ir[AW-1:0];
      else if (ctl.mar_from_save) mar <= AW'(SAVE_ADDR);

      if (ctl.mbr_from_mem)      mbr <= rdata;
      else if (ctl.mbr_from_pc)  mbr <= {{PADW{1'b0}}, pc};
      else if (ctl.mbr_inc)      mbr <= mbr + DW'(1);

      if (ctl.pc_from_ir)        pc <= ir[AW-1:0];
      else if (ctl.pc_from_isr)  pc <= AW'(ISR_ADDR);
      else if (ctl.pc_inc)       pc <= pc + AW'(1);

      if (ctl.ir_from_mbr)          ir <= mbr[DW-2:0];
      else if (ctl.iraddr_from_mbr) ir[AW-1:0] <= mbr[AW-1:0];

      if (ctl.acc_add) acc <= acc + mbr;
      if (ctl.ie_clr)  ie  <= 1'b0;
    end
  end

endmodule

// File: rtl/hwseq_core.sv
module hwseq_core
  import hwseq_pkg::*;
#(
  parameter int AW        = 12,
  parameter int DW        = 16,
  parameter int SAVE_ADDR = 0,
  parameter int ISR_ADDR  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] acc_out,
  output logic          halted
);

  phase_t            phase;
  logic [STEP_W-1:0] step;
  ctl_t              ctl;
  logic [AW-1:0]     mar;
  logic [DW-1:0]     mbr;
  logic [2:0]        opcode;
  logic              ie;

  hwseq_timing u_timing (
    .clk      (clk),
    .rst_n    (rst_n),
    .last     (ctl.last),
    .nxt      (ctl.nxt),
    .halt_set (ctl.halt_set),
    .phase    (phase),
    .step     (step),
    .halted   (halted)
  );

  hwseq_decode u_decode (
    .phase    (phase),
    .step     (step),
    .opcode   (opcode),
    .mbr_ind  (mbr[DW-1]),
    .mbr_zero (mbr == '0),
    .irq      (irq),
    .ie       (ie),
    .halted   (halted),
    .ctl      (ctl)
  );

  hwseq_datapath #(
    .AW        (AW),
    .DW        (DW),
    .SAVE_ADDR (SAVE_ADDR),
    .ISR_ADDR  (ISR_ADDR)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .rdata  (mem_rdata),
    .mar    (mar),
    .mbr    (mbr),
    .acc    (acc_out),
    .opcode (opcode),
    .ie     (ie)
  );

  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_rd    = ctl.mem_rd;
  assign mem_wr    = ctl.mem_wr;

endmodule

// File: rtl/hwseq_core_chk.sv
module hwseq_core_chk
  import hwseq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              halted,
  input phase_t            phase,
  input logic [STEP_W-1:0] step,
  input logic              ie
);

  // R10
  rw_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R8
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_rd && !mem_wr));

  // R2
  fetch_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FETCH) |-> !mem_wr);

  // R2
  fetch_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FETCH) |-> (step <= 2'd2));

  // R7
  ie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ie) |-> ($past(phase) == PH_INT));

  // R7
  int_from_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phase == PH_INT) |-> ($past(phase) == PH_EXEC && $past(ie)));

endmodule

bind hwseq_core hwseq_core_chk i_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .mem_rd (mem_rd),
  .mem_wr (mem_wr),
  .halted (halted),
  .phase  (phase),
  .step   (step),
  .ie     (ie)
);

// File: tb/test_hwseq_core.sv
`timescale 1ns/1ps
module test_hwseq_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 1'b0;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_wdata, mem_rdata, acc_out;
  logic        halted;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] mem     [256];
  logic [15:0] ref_mem [256];
  logic        tr_rd   [64];
  logic        tr_wr   [64];
  logic [11:0] tr_addr [64];

  always #2.5 clk = ~clk;

  hwseq_core i_hwseq_core (
    .clk (clk), .rst_n (rst_n), .irq (irq),
    .mem_addr (mem_addr), .mem_rd (mem_rd), .mem_wr (mem_wr),
    .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
    .acc_out (acc_out), .halted (halted)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

  function automatic logic [15:0] ins(input bit ind, input logic [2:0] op, input logic [11:0] a);
    return {ind, op, a};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int a = 0; a < 256; a++) mem[a] = 16'h0;
  endtask

  task automatic run_prog(output int n);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    while (!halted && n < 800) begin
      if (n < 64) begin
        tr_rd[n] = mem_rd; tr_wr[n] = mem_wr; tr_addr[n] = mem_addr;
      end
      @(posedge clk);
      @(negedge clk);
      n++;
    end
  endtask

  task automatic check_rw_excl(input string tag, input int n);
    int bad = 0;
    for (int k = 0; k < 64 && k < n; k++) if (tr_rd[k] && tr_wr[k]) bad++;
    chk("R10", tag, bad, 0);
  endtask

  task automatic model(output int cyc, output logic [15:0] acc);
    logic [11:0] pc, ea;
    logic [15:0] w, v;
    cyc = 0; acc = 16'h0; pc = 12'h0;
    for (int k = 0; k < 64; k++) begin
      w = ref_mem[pc[7:0]];
      pc = pc + 12'd1;
      cyc += 3;
      ea = w[11:0];
      if (w[15]) begin
        cyc += 3;
        ea = ref_mem[ea[7:0]][11:0];
      end
      case (w[14:12])
        3'b000: begin acc = acc + ref_mem[ea[7:0]]; cyc += 3; end
        3'b001: begin
          v = ref_mem[ea[7:0]] + 16'd1;
          ref_mem[ea[7:0]] = v;
          if (v == 16'h0) pc = pc + 12'd1;
          cyc += 4;
        end
        3'b010: begin ref_mem[ea[7:0]] = {4'h0, pc}; pc = ea + 12'd1; cyc += 3; end
        3'b111: begin cyc += 1; break; end
        default: cyc += 1;
      endcase
    end
  endtask

  initial begin
    #800us;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, exp_n, bad, x, r;
    logic [15:0] exp_acc;
    void'($urandom(32'h5eed));

    // R1 reset state
    #1;
    chk("R1", "halted in reset", halted, 0);
    chk("R1", "acc in reset", acc_out, 0);
    chk("R1", "strobes in reset", {mem_rd, mem_wr}, 0);

    // R2 R4 direct add
    clear_mem();
    mem[0] = ins(0, 3'b000, 12'h080);
    mem[1] = ins(0, 3'b111, 12'h000);
    mem[8'h80] = 16'h1234;
    run_prog(n);
    chk("R2", "fetch cycle1 no read", tr_rd[0], 0);
    chk("R2", "fetch read at pc0", {tr_rd[1], tr_addr[1]}, {1'b1, 12'h000});
    chk("R4", "operand read", {tr_rd[4], tr_addr[4]}, {1'b1, 12'h080});
    chk("R4", "acc", acc_out, 16'h1234);
    chk("R8", "halt cycles", n, 10);
    check_rw_excl("add", n);

    // R1 reset clears a halted core
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1", "halted cleared", halted, 0);
    chk("R1", "acc cleared", acc_out, 0);
    chk("R1", "addr cleared", mem_addr, 0);

    // R5 increment to zero skips
    clear_mem();
    mem[0] = ins(0, 3'b001, 12'h081);
    mem[1] = ins(0, 3'b000, 12'h080);
    mem[2] = ins(0, 3'b111, 12'h000);
    mem[8'h80] = 16'h0007;
    mem[8'h81] = 16'hFFFF;
    run_prog(n);
    chk("R5", "write cycle", {tr_wr[6], tr_addr[6]}, {1'b1, 12'h081});
    chk("R5", "wrapped value", mem[8'h81], 16'h0000);
    chk("R5", "skipped add", acc_out, 16'h0000);
    chk("R5", "cycles skip", n, 11);

    // R5 nonzero no skip
    mem[8'h81] = 16'h0005;
    run_prog(n);
    chk("R5", "incremented", mem[8'h81], 16'h0006);
    chk("R5", "no skip acc", acc_out, 16'h0007);
    chk("R5", "cycles noskip", n, 17);

    // R3 indirect add
    clear_mem();
    mem[0] = ins(1, 3'b000, 12'h040);
    mem[1] = ins(0, 3'b111, 12'h000);
    mem[8'h40] = 16'hF082;
    mem[8'h82] = 16'h0101;
    run_prog(n);
    chk("R3", "pointer read", {tr_rd[4], tr_addr[4]}, {1'b1, 12'h040});
    chk("R3", "operand read", {tr_rd[7], tr_addr[7]}, {1'b1, 12'h082});
    chk("R3", "acc", acc_out, 16'h0101);
    chk("R3", "cycles", n, 13);

    // R6 branch and save
    clear_mem();
    mem[0] = ins(0, 3'b000, 12'h080);
    mem[1] = ins(0, 3'b010, 12'h020);
    mem[8'h21] = ins(0, 3'b111, 12'h000);
    mem[8'h80] = 16'h0003;
    run_prog(n);
    chk("R6", "save write", {tr_wr[10], tr_addr[10]}, {1'b1, 12'h020});
    chk("R6", "saved address", mem[8'h20], 16'h0002);
    chk("R6", "cycles", n, 16);
    check_rw_excl("bsa", n);

    // R7 interrupt entry, second request ignored
    clear_mem();
    mem[0] = ins(0, 3'b010, 12'h010);
    mem[1] = ins(0, 3'b000, 12'h020);
    mem[2] = ins(0, 3'b111, 12'h000);
    mem[8'h20] = 16'h0005;
    irq = 1'b1;
    run_prog(n);
    chk("R7", "save write", {tr_wr[8], tr_addr[8]}, {1'b1, 12'h000});
    chk("R7", "saved pc", mem[0], 16'h0011);
    chk("R6", "bsa before int", mem[8'h10], 16'h0001);
    chk("R7", "routine ran once", acc_out, 16'h0005);
    chk("R7", "cycles", n, 19);

    // R8 halted stays, no strobes, irq still high
    bad = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (!halted || mem_rd || mem_wr) bad++;
    end
    chk("R8", "halt sticky and quiet", bad, 0);
    irq = 1'b0;

    // R9 unused opcodes
    clear_mem();
    mem[0] = ins(0, 3'b011, 12'h080);
    mem[1] = ins(0, 3'b110, 12'h081);
    mem[2] = ins(0, 3'b111, 12'h000);
    mem[8'h80] = 16'h0042;
    mem[8'h81] = 16'h0043;
    run_prog(n);
    chk("R9", "cycles", n, 12);
    chk("R9", "acc untouched", acc_out, 0);
    chk("R9", "memory untouched", {mem[8'h80], mem[8'h81]}, {16'h0042, 16'h0043});

    // R2 R3 R4 R5 R6 R9 random programs against instruction-level model
    for (int t = 0; t < 40; t++) begin
      clear_mem();
      for (int k = 0; k < 16; k++) begin
        mem[8'h80 + k] = ($urandom % 4 == 0) ? 16'hFFFF : 16'($urandom);
        mem[8'h40 + k] = {4'($urandom), 12'h080 + 12'(k)};
      end
      for (int i = 0; i < 15; i++) begin
        r = $urandom % 8;
        x = $urandom % 16;
        if (r == 5 && i <= 13)
          mem[i] = ins(0, 3'b010, 12'(i + 1 + ($urandom % (14 - i))));
        else if (r == 6)
          mem[i] = ins(0, 3'(3 + ($urandom % 4)), 12'(x));
        else if (r == 3 || r == 4)
          mem[i] = ($urandom % 4 == 0) ? ins(1, 3'b001, 12'h040 + 12'(x)) : ins(0, 3'b001, 12'h080 + 12'(x));
        else
          mem[i] = ($urandom % 4 == 0) ? ins(1, 3'b000, 12'h040 + 12'(x)) : ins(0, 3'b000, 12'h080 + 12'(x));
      end
      mem[15] = ins(0, 3'b111, 12'($urandom));
      mem[16] = ins(0, 3'b111, 12'h000);
      for (int a = 0; a < 256; a++) ref_mem[a] = mem[a];
      model(exp_n, exp_acc);
      run_prog(n);
      chk("R4", "random acc", acc_out, exp_acc);
      chk("R2", "random cycles", n, exp_n);
      bad = 0;
      for (int a = 0; a < 256; a++) if (mem[a] !== ref_mem[a]) bad++;
      chk("R5", "random memory image", bad, 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule